// File: doc/BRIEF.md
# Branch Target Address Cache

This block is a small, fully associative table that a fetch stage uses to guess where a branch will go. Each slot stores a valid flag, a tag taken from the word-aligned branch address, the predicted target, and a 2-bit saturating direction counter. Every cycle the fetch stage presents an address. In the same cycle, without a clock edge in between, the block reports whether a slot matches, whether that slot predicts the branch as taken, and the stored target.

The execute stage reports each resolved branch on one of two ports. It uses the allocate port when the branch has no history, so a slot is created for it. It uses the update port when a slot already exists, so that slot is trained. The first execution of any branch therefore has no dynamic prediction. Several controls manage the table:

- An enable input switches prediction on and off.
- A global flush input clears the whole table.
- An address-based flush clears a single slot.
- A process-identifier input clears the whole table whenever its value changes.

Top module: `btac_cache`

## Requirements
- R1: After reset every slot is invalid and no lookup reports a hit.
- R2: With `en` high, `lk_hit` is 1 in the same cycle when a valid slot's tag equals `lk_addr[AW-1:2]`. Address bits [1:0] play no part in matching. On a hit, `lk_taken` equals bit 1 of the slot's counter and `lk_target` is the stored target.
- R3: Counter encoding: 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken, 3 = strongly taken. A slot created by allocation starts at 2 if `al_taken` is set and at 1 otherwise. The new slot can be looked up from the next cycle.
- R4: An allocation whose address already matches a valid slot rewrites that slot. It never creates a second slot for the same address.
- R5: A new allocation goes to the lowest-numbered invalid slot. When every slot is valid, it goes to the slot named by a rotating pointer. That pointer starts at 0 after reset and advances by one, wrapping, only when it is used.
- R6: An update that matches a slot changes the counter as follows:
  - when taken, the counter increments, saturating at 3, and the stored target is replaced by `up_target`;
  - when not taken, the counter decrements, saturating at 0.
  An update that matches no slot has no effect.
- R7: A lookup made in the same cycle as an allocation, update or flush sees the table as it was before that cycle's write.
- R8: With `en` low, `lk_hit` is 0. Slot contents are kept, and allocation and update still act on them.
- R9: `flush_all` invalidates every slot at the next edge and overrides any allocation, update or single flush in the same cycle.
- R10: Any change in the value of `pid` from the previous cycle invalidates every slot, in the same way as `flush_all`.
- R11: `flush_one` invalidates only the slot that matched `flush_addr` before that cycle's writes, and it applies after them. All other slots are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Prediction enable |
| flush_all | input | 1 | Invalidate all slots |
| flush_one | input | 1 | Invalidate the slot matching `flush_addr` |
| flush_addr | input | AW | Address for the single-slot flush |
| pid | input | PIDW | Current process identifier |
| lk_addr | input | AW | Fetch lookup address |
| lk_hit | output | 1 | Lookup matched a valid slot while enabled |
| lk_taken | output | 1 | Matched slot predicts taken |
| lk_target | output | AW | Predicted target |
| al_valid | input | 1 | Allocate request |
| al_addr | input | AW | Branch address to allocate |
| al_target | input | AW | Resolved target |
| al_taken | input | 1 | Resolved direction |
| up_valid | input | 1 | Update request |
| up_addr | input | AW | Branch address to update |
| up_target | input | AW | Resolved target |
| up_taken | input | 1 | Resolved direction |

## Verification
The bench builds the block with ENTRIES=4, AW=16 and PIDW=4. With only four slots, random allocations drawn from a pool of six branch addresses fill the table within a few cycles. This exercises the rotating replacement pointer and its wrap over and over, and makes same-address collisions between allocate, update, lookup and single flush frequent. The narrow process identifier makes random context changes common, so flush-on-change interleaves with training.

// File: rtl/btac_cache.sv
module btac_cache #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int PIDW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            flush_all,
  input  logic            flush_one,
  input  logic [AW-1:0]   flush_addr,
  input  logic [PIDW-1:0] pid,
  input  logic [AW-1:0]   lk_addr,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [AW-1:0]   lk_target,
  input  logic            al_valid,
  input  logic [AW-1:0]   al_addr,
  input  logic [AW-1:0]   al_target,
  input  logic            al_taken,
  input  logic            up_valid,
  input  logic [AW-1:0]   up_addr,
  input  logic [AW-1:0]   up_target,
  input  logic            up_taken
);
  localparam int TW = AW - 2;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [TW-1:0]      tag [ENTRIES];
  logic [AW-1:0]      tgt [ENTRIES];
  logic [1:0]         ctr [ENTRIES];
  logic [IW-1:0]      rr;
  logic [PIDW-1:0]    pid_q;

  logic [ENTRIES-1:0] lk_m, al_m, up_m, fl_m;
  logic [IW-1:0]      lk_i, al_mi, up_i, free_i, al_i;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_m[i] = vld[i] && tag[i] == lk_addr[AW-1:2];
    assign al_m[i] = vld[i] && tag[i] == al_addr[AW-1:2];
    assign up_m[i] = vld[i] && tag[i] == up_addr[AW-1:2];
    assign fl_m[i] = vld[i] && tag[i] == flush_addr[AW-1:2];
  end

  always_comb begin
    lk_i = '0; al_mi = '0; up_i = '0; free_i = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_m[i]) lk_i   = IW'(i);
      if (al_m[i]) al_mi  = IW'(i);
      if (up_m[i]) up_i   = IW'(i);
      if (!vld[i]) free_i = IW'(i);
    end
  end

  wire gflush  = flush_all || (pid != pid_q);
  wire al_new  = al_valid && !(|al_m);
  wire repl    = al_new && (&vld);
  wire up_hit  = up_valid && (|up_m);
  assign al_i  = (|al_m) ? al_mi : (repl ? rr : free_i);

  assign lk_hit    = en && (|lk_m);
  assign lk_taken  = lk_hit && ctr[lk_i][1];
  assign lk_target = lk_hit ? tgt[lk_i] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= '0;
      rr    <= '0;
      pid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        tgt[i] <= '0;
        ctr[i] <= 2'd0;
      end
    end else begin
      pid_q <= pid;
      if (gflush) begin
        vld <= '0;
      end else begin
        if (up_hit) begin
          if (up_taken) begin
            ctr[up_i] <= (ctr[up_i] == 2'd3) ? 2'd3 : ctr[up_i] + 2'd1;
            tgt[up_i] <= up_target;
          end else begin
            ctr[up_i] <= (ctr[up_i] == 2'd0) ? 2'd0 : ctr[up_i] - 2'd1;
          end
        end
        if (al_valid) begin
          vld[al_i] <= 1'b1;
          tag[al_i] <= al_addr[AW-1:2];
          tgt[al_i] <= al_target;
          ctr[al_i] <= al_taken ? 2'd2 : 2'd1;
          if (repl) rr <= (rr == IW'(ENTRIES - 1)) ? '0 : rr + 1'b1;
        end
        if (flush_one)
          for (int i = 0; i < ENTRIES; i++)
            if (fl_m[i]) vld[i] <= 1'b0;
      end
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m)); // R4
  AST_NO_HIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !lk_hit); // R8
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (vld == '0)); // R9
  AST_PID_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (pid != pid_q) |=> (vld == '0)); // R10
  AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (al_new && !(&vld) && !flush_one && !gflush)
      |=> $countones(vld) == $past($countones(vld)) + 1); // R5
  AST_UPD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !al_valid && !flush_one && !gflush)
      |=> $countones(vld) == $past($countones(vld))); // R6
endmodule

// File: tb/sim_btac_cache.sv
module sim_btac_cache;
  localparam int N = 4, AW = 16, PW = 4;

  logic clk = 0, rst_n = 0;
  logic en = 1, flush_all = 0, flush_one = 0;
  logic [AW-1:0] flush_addr = '0;
  logic [PW-1:0] pid = '0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_hit, lk_taken;
  logic [AW-1:0] lk_target;
  logic al_valid = 0, al_taken = 0, up_valid = 0, up_taken = 0;
  logic [AW-1:0] al_addr = '0, al_target = '0, up_addr = '0, up_target = '0;

  btac_cache #(.ENTRIES(N), .AW(AW), .PIDW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .flush_all(flush_all), .flush_one(flush_one),
    .flush_addr(flush_addr), .pid(pid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .lk_target(lk_target), .al_valid(al_valid), .al_addr(al_addr),
    .al_target(al_target), .al_taken(al_taken), .up_valid(up_valid), .up_addr(up_addr),
    .up_target(up_target), .up_taken(up_taken));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit         mv   [N];
  logic [AW-3:0] mtag [N];
  logic [AW-1:0] mtgt [N];
  logic [1:0]    mctr [N];
  int mrr = 0;
  logic [PW-1:0] mpid = '0;

  function automatic int mfind(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (mv[i] && mtag[i] == a[AW-1:2]) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] pick_addr();
    return AW'((($urandom % 6) + 1) * 16'h0104 + ($urandom % 4));
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic look(string r);
    int k = mfind(lk_addr);
    logic eh = en && k >= 0;
    chk(r, 32'(lk_hit), 32'(eh));
    if (eh) begin
      chk(r, 32'(lk_taken), 32'(mctr[k][1]));
      chk(r, 32'(lk_target), 32'(mtgt[k]));
    end
  endtask

  task automatic model_edge();
    int fi = flush_one ? mfind(flush_addr) : -1;
    if (flush_all || pid != mpid) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else begin
      if (up_valid) begin
        int k = mfind(up_addr);
        if (k >= 0) begin
          if (up_taken) begin
            if (mctr[k] != 3) mctr[k]++;
            mtgt[k] = up_target;
          end else if (mctr[k] != 0) mctr[k]--;
        end
      end
      if (al_valid) begin
        int k = mfind(al_addr);
        if (k < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) k = i;
        if (k < 0) begin k = mrr; mrr = (mrr + 1) % N; end
        mv[k] = 1; mtag[k] = al_addr[AW-1:2]; mtgt[k] = al_target;
        mctr[k] = al_taken ? 2'd2 : 2'd1;
      end
      if (fi >= 0) mv[fi] = 0;
    end
    mpid = pid;
  endtask

  task automatic step(string r);
    #5 look(r);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    al_valid = 0; up_valid = 0; flush_all = 0; flush_one = 0;
  endtask

  task automatic alloc(logic [AW-1:0] a, logic [AW-1:0] t, logic tk);
    al_valid = 1; al_addr = a; al_target = t; al_taken = tk; lk_addr = a;
    step("R7");
  endtask

  task automatic upd(logic [AW-1:0] a, logic [AW-1:0] t, logic tk);
    up_valid = 1; up_addr = a; up_target = t; up_taken = tk; lk_addr = a;
    step("R7");
  endtask

  task automatic probe(logic [AW-1:0] a, string r);
    lk_addr = a; step(r);
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) mv[i] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    probe(16'h0100, "R1"); probe(16'h0000, "R1");
    // R3 weak states, R2 low bits ignored
    alloc(16'h0100, 16'h1230, 1); probe(16'h0103, "R3");
    chk("R3", 32'(lk_taken), 32'(1));
    alloc(16'h0200, 16'h4560, 0); probe(16'h0200, "R3");
    chk("R3", 32'(lk_taken), 32'(0));
    // R6 saturation up and down, target rewrite
    upd(16'h0100, 16'h1110, 1); upd(16'h0100, 16'h2220, 1); upd(16'h0100, 16'h3330, 1);
    probe(16'h0100, "R6"); chk("R6", 32'(lk_target), 32'h3330);
    upd(16'h0100, 16'h9990, 0); probe(16'h0100, "R6"); chk("R6", 32'(lk_taken), 32'(1));
    upd(16'h0100, 16'h9990, 0); probe(16'h0100, "R6"); chk("R6", 32'(lk_taken), 32'(0));
    upd(16'h0100, 16'h9990, 0); upd(16'h0100, 16'h9990, 0);
    upd(16'h0100, 16'h7770, 1); probe(16'h0100, "R6"); chk("R6", 32'(lk_taken), 32'(0));
    upd(16'h0900, 16'h5550, 1); probe(16'h0900, "R6");
    // R4 re-allocate same address
    alloc(16'h0200, 16'h6660, 1); probe(16'h0200, "R4"); chk("R4", 32'(lk_target), 32'h6660);
    // R5 fill and replacement order
    alloc(16'h0300, 16'h0030, 1); alloc(16'h0400, 16'h0040, 1);
    alloc(16'h0500, 16'h0050, 1); probe(16'h0100, "R5"); chk("R5", 32'(lk_hit), 32'(0));
    alloc(16'h0600, 16'h0060, 1); probe(16'h0200, "R5"); chk("R5", 32'(lk_hit), 32'(0));
    // R11 single flush
    flush_one = 1; flush_addr = 16'h0302; probe(16'h0300, "R11");
    probe(16'h0300, "R11"); chk("R11", 32'(lk_hit), 32'(0)); probe(16'h0400, "R11");
    // R8 disable keeps contents and training
    en = 0; probe(16'h0400, "R8"); upd(16'h0400, 16'h0444, 1);
    en = 1; probe(16'h0400, "R8"); chk("R8", 32'(lk_target), 32'h0444);
    // R9 global flush beats allocation
    flush_all = 1; al_valid = 1; al_addr = 16'h0700; al_target = 16'h0070; al_taken = 1;
    probe(16'h0400, "R9"); probe(16'h0700, "R9"); chk("R9", 32'(lk_hit), 32'(0));
    // R10 pid change
    alloc(16'h0800, 16'h0080, 1); pid = 4'd3; probe(16'h0800, "R10");
    probe(16'h0800, "R10"); chk("R10", 32'(lk_hit), 32'(0));
    // random mix
    for (int n = 0; n < 3000; n++) begin
      en = ($urandom % 8) != 0;
      lk_addr = pick_addr();
      al_valid = ($urandom % 3) == 0; al_addr = pick_addr();
      al_target = AW'($urandom); al_taken = $urandom % 2;
      up_valid = ($urandom % 2) == 0; up_addr = pick_addr();
      up_target = AW'($urandom); up_taken = $urandom % 2;
      flush_one = ($urandom % 16) == 0; flush_addr = pick_addr();
      flush_all = ($urandom % 64) == 0;
      if (($urandom % 64) == 0) pid = PW'($urandom);
      step("R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule